// File: doc/BRIEF.md
# Latched-Address SRAM Cycle Controller

This block is a synchronous master that turns single-word requests into read and write cycles on a 2048 x 8 asynchronous static RAM. The RAM captures its address when chip enable falls. Every timing limit is given as a nanosecond parameter. The controller converts each one into a whole number of system clocks, rounding up. With the defaults (20 ns clock) the derived counts are:

| Phase | Cycles |
|---|---|
| Address setup | 1 |
| Address hold | 3 |
| Read chip-enable low | 11 |
| Write chip-enable low | 10 |
| Precharge | 4 |
| Data hold | 1 |
| Minimum cycle | 14 |

On the user side, a request is taken when `req` and `ready` are both high. The request carries an address, a direction flag, write data and a burst flag. Read data returns with a one-clock `rd_valid` strobe.

On the memory side, the block drives active-low chip enable, output enable and write enable, plus the address. The data bus is split into an output value, an input value and a driver enable.

A write request with the burst flag set leaves write enable low after the cycle ends. In that case each following write is committed by the rising edge of chip enable.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `ready` is 1.
- R2: `ready` is high only while no cycle is in progress, and it drops in the clock after a request is accepted. `mem_addr` carries the request address at least one clock before `mem_ce_n` falls.
- R3: A read holds `mem_ce_n` low for exactly 11 clocks. `mem_oe_n` is low with it and `mem_we_n` stays high throughout. `rdata` is the value present on `mem_dq_in` in the last chip-enable-low clock. `rd_valid` is high for exactly one clock, 13 clocks after the accepting edge.
- R4: A write keeps `mem_oe_n` high. `mem_we_n` falls before `mem_ce_n` falls, and `mem_ce_n` is low for exactly 10 clocks. `mem_dq_oe` drives `wdata` from the address phase until 1 clock after `mem_ce_n` rises, and then releases the bus. The RAM commits on that rise.
- R5: Between two cycles `mem_ce_n` stays high for at least 4 clocks. Successive falling edges of `mem_ce_n` are at least 14 clocks apart.
- R6: After a write accepted with `burst`=1, `mem_we_n` remains low while the block is idle. After a write with `burst`=0, `mem_we_n` returns high. A read that follows a held write raises `mem_we_n` before `mem_ce_n` falls.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: `mem_addr` does not change while `mem_ce_n` is low.
- R9: `req` raised while `ready` is low and dropped before `ready` returns starts no cycle and changes no RAM location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe |
| ready | output | 1 | Controller idle, request accepted |
| wr | input | 1 | 1 = write, 0 = read |
| burst | input | 1 | Keep write enable low after this write |
| addr | input | 11 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | One-clock read-data strobe |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_addr | output | 11 | RAM address |
| mem_dq_out | output | 8 | Data driven toward RAM |
| mem_dq_in | input | 8 | Data returned by RAM |
| mem_dq_oe | output | 1 | Enable for the master data driver |

## Verification
The RAM model in the bench returns inverted data until 11 chip-enable-low clocks have passed. A controller that samples one clock early therefore returns wrong read data, and one that samples late misses the expected `rd_valid` latency.

The bench runs burst write runs followed by reads. A design that lets write enable rise between held writes, or that leaves it low into a read, shows up either as a wrong idle level of `mem_we_n` or as a write-enable/output-enable overlap. A design that drops the data driver at the terminating edge, or holds it too long, fails the hold-window check. Requests pulsed while the controller is busy must leave the number of chip-enable cycles and the memory contents unchanged.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int CLK_NS = 20,
  parameter int ASU_NS = 0,
  parameter int AH_NS  = 50,
  parameter int ACC_NS = 200,
  parameter int WP_NS  = 200,
  parameter int DS_NS  = 80,
  parameter int DH_NS  = 10,
  parameter int PRE_NS = 80,
  parameter int CYC_NS = 280
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          ready,
  input  logic          wr,
  input  logic          burst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ASU_C  = imax(1, cdiv(ASU_NS));
  localparam int AH_C   = imax(1, cdiv(AH_NS));
  localparam int RD_CE  = imax(AH_C + 2, cdiv(ACC_NS) + 1);
  localparam int WR_CE  = imax(AH_C + 2, imax(cdiv(WP_NS), cdiv(DS_NS)));
  localparam int DH_C   = imax(1, cdiv(DH_NS));
  localparam int PRE_B  = imax(cdiv(PRE_NS), DH_C);
  localparam int CYC_C  = cdiv(CYC_NS);
  localparam int PRE_RD = imax(PRE_B, CYC_C - ASU_C - RD_CE - 1);
  localparam int PRE_WR = imax(PRE_B, CYC_C - ASU_C - WR_CE - 1);
  localparam int RD_ACC = RD_CE - AH_C - 1;
  localparam int WR_ACC = WR_CE - AH_C - 1;
  localparam int CW     = $clog2(CYC_C + RD_CE + WR_CE + PRE_RD + PRE_WR + ASU_C + 2);

  typedef enum logic [2:0] {
    IDLE, ADDR_SETUP, CE_LOW_HOLD, ACCESS, CAPTURE, CE_HIGH_PRECHARGE
  } state_t;

  state_t          st;
  logic [CW-1:0]   cnt, dh_cnt;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            wr_q, hold_q, we_low, drv;

  wire ce_low = (st == CE_LOW_HOLD) || (st == ACCESS) || (st == CAPTURE);

  assign ready      = (st == IDLE);
  assign mem_ce_n   = !ce_low;
  assign mem_oe_n   = !(ce_low && !wr_q);
  assign mem_we_n   = !we_low;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      dh_cnt   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      hold_q   <= 1'b0;
      we_low   <= 1'b0;
      drv      <= 1'b0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        IDLE: if (req) begin
          st      <= ADDR_SETUP;
          cnt     <= CW'(ASU_C - 1);
          addr_q  <= addr;
          wdata_q <= wdata;
          wr_q    <= wr;
          hold_q  <= wr && burst;
          we_low  <= wr;
          drv     <= wr;
        end
        ADDR_SETUP:
          if (cnt == '0) begin
            st  <= CE_LOW_HOLD;
            cnt <= CW'(AH_C - 1);
          end else cnt <= cnt - 1'b1;
        CE_LOW_HOLD:
          if (cnt == '0) begin
            st  <= ACCESS;
            cnt <= wr_q ? CW'(WR_ACC - 1) : CW'(RD_ACC - 1);
          end else cnt <= cnt - 1'b1;
        ACCESS:
          if (cnt == '0) st <= CAPTURE;
          else cnt <= cnt - 1'b1;
        CAPTURE: begin
          st     <= CE_HIGH_PRECHARGE;
          cnt    <= wr_q ? CW'(PRE_WR - 1) : CW'(PRE_RD - 1);
          dh_cnt <= CW'(DH_C);
          if (!wr_q) begin
            rdata    <= mem_dq_in;
            rd_valid <= 1'b1;
          end
          if (!hold_q) we_low <= 1'b0;
        end
        CE_HIGH_PRECHARGE: begin
          if (dh_cnt != '0) begin
            dh_cnt <= dh_cnt - 1'b1;
            if (dh_cnt == CW'(1)) drv <= 1'b0;
          end
          if (cnt == '0) st <= IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [CW-1:0] lo_run, hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= CW'(PRE_B);
    end else begin
      lo_run <= mem_ce_n ? '0 : lo_run + 1'b1;
      hi_run <= !mem_ce_n ? '0 : ((hi_run < CW'(PRE_B)) ? hi_run + 1'b1 : hi_run);
    end
  end

  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);  // R3
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !mem_ce_n) |-> mem_oe_n);  // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);  // R7
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> ($past(hi_run) >= CW'(PRE_B - 1)));  // R5
  AST_CE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> ($past(lo_run) >= CW'(imax(0, (RD_CE < WR_CE ? RD_CE : WR_CE) - 1))));  // R4
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);  // R3
  AST_READY_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce_n);  // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));  // R8

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;
  localparam int RD_CE = 11, WR_CE = 10, PRE = 4, CYC = 14, RD_LAT = 13, ACC_OK = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req = 0, wr = 0, burst = 0, ready, rd_valid;
  logic [10:0] addr = '0, mem_addr;
  logic [7:0] wdata = '0, rdata, mem_dq_out, mem_dq_in = '0;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  sram_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr), .burst(burst),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe));

  logic [7:0] ram [0:2047];
  logic [7:0] shadow [0:2047];
  int checks = 0, fails = 0, cyc = 0;
  int cont_err = 0, we_err = 0, addr_err = 0, ce_falls = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_rd(input logic [10:0] a);
    return shadow[a];
  endfunction

  // RAM model and protocol monitor
  logic p_ce = 1, p_we = 1, p_drv = 0;
  logic [7:0] p_dout = '0;
  logic [10:0] p_addr = '0, lat_addr = '0;
  int lo = 0, hi = 1000, since_fall = 1000;
  bit was_read = 0, dh_watch = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_fall++;
      if (!mem_ce_n && p_ce) begin
        ce_falls++;
        chk(mem_addr == p_addr, "R2 address set up before CE falls", mem_addr, p_addr);
        chk(hi >= PRE, "R5 CE high time", hi, PRE);
        chk(since_fall >= CYC, "R5 cycle period", since_fall, CYC);
        lat_addr = mem_addr; lo = 1; since_fall = 0; was_read = 0;
      end else if (!mem_ce_n) begin
        lo++;
        if (mem_addr != p_addr) addr_err++;
      end
      if (!mem_ce_n && !mem_oe_n) was_read = 1;
      if (mem_ce_n && !p_ce) begin
        chk(lo == (was_read ? RD_CE : WR_CE), was_read ? "R3 CE low length" : "R4 CE low length",
            lo, was_read ? RD_CE : WR_CE);
        if (!p_we && !was_read) begin
          ram[lat_addr] = p_dout;
          chk(p_drv && mem_dq_oe, "R4 data driven through end-of-write", mem_dq_oe, 1);
          dh_watch = 1;
        end
        hi = 1;
      end else if (mem_ce_n) begin
        if (dh_watch) begin
          chk(!mem_dq_oe, "R4 driver released after hold", mem_dq_oe, 0);
          dh_watch = 0;
        end
        hi++;
      end
      if (!mem_oe_n && mem_dq_oe) cont_err++;
      if (!mem_oe_n && !mem_we_n) we_err++;
      if (!mem_ce_n && !mem_oe_n && mem_we_n)
        mem_dq_in = (lo >= ACC_OK) ? ram[lat_addr] : ~ram[lat_addr];
      else
        mem_dq_in = 8'h00;
      p_ce = mem_ce_n; p_we = mem_we_n; p_drv = mem_dq_oe;
      p_dout = mem_dq_out; p_addr = mem_addr;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      chk(cont_err == 0, "R7 no driver while OE low", cont_err, 0);
      chk(we_err == 0, "R3 WE high during read", we_err, 0);
      chk(addr_err == 0, "R8 address stable while CE low", addr_err, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic wait_idle();
    while (!ready) @(negedge clk);
  endtask

  task automatic do_op(input bit w, input bit b, input logic [10:0] a, input logic [7:0] d);
    wait_idle();
    req = 1; wr = w; burst = b; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    chk(!ready, "R2 ready drops after accept", ready, 0);
    if (w) shadow[a] = d;
    else begin
      int n = 1;
      while (!rd_valid && n < 100) begin @(negedge clk); n++; end
      chk(n == RD_LAT, "R3 read latency", n, RD_LAT);
      chk(rdata == expect_rd(a), "R3 read data", rdata, expect_rd(a));
      @(negedge clk);
      chk(!rd_valid, "R3 single strobe", rd_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 2048; i++) begin
      ram[i] = 8'(i ^ 8'h3C);
      shadow[i] = 8'(i ^ 8'h3C);
    end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid, "R1 reset outputs",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset", {ready, mem_ce_n, mem_dq_oe}, 3'b110);

    do_op(1, 0, 11'd0, 8'hA5);
    do_op(1, 0, 11'd2047, 8'h5A);
    wait_idle();
    chk(mem_we_n, "R6 WE high after plain write", mem_we_n, 1);
    do_op(0, 0, 11'd0, 0);
    do_op(0, 0, 11'd2047, 0);

    do_op(1, 1, 11'd10, 8'h11);
    wait_idle();
    chk(!mem_we_n, "R6 WE held low after burst write", mem_we_n, 0);
    do_op(1, 1, 11'd11, 8'h22);
    do_op(1, 1, 11'd12, 8'h33);
    wait_idle();
    chk(!mem_we_n, "R6 WE still low in burst", mem_we_n, 0);
    do_op(0, 0, 11'd10, 0);
    chk(mem_we_n, "R6 read raised WE", mem_we_n, 1);
    do_op(0, 0, 11'd11, 0);
    do_op(0, 0, 11'd12, 0);

    begin
      int f0;
      wait_idle();
      f0 = ce_falls;
      do_op(1, 0, 11'd100, 8'hC3);
      req = 1; wr = 1; burst = 0; addr = 11'd200; wdata = 8'h77;
      repeat (3) @(negedge clk);
      req = 0;
      wait_idle();
      chk(ce_falls == f0 + 1, "R9 busy request ignored", ce_falls - f0, 1);
      do_op(0, 0, 11'd200, 0);
      do_op(0, 0, 11'd100, 0);
    end

    for (int k = 0; k < 300; k++) begin
      bit w = 1'($urandom % 2);
      bit b = w && ($urandom % 3 == 0);
      do_op(w, b, 11'($urandom), 8'($urandom));
    end
    wait_idle();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule